// File: doc/BRIEF.md
# Per-Channel Reset and Interrupt Aggregation Register Block

This block is the global control corner of a multi-channel line-interface device. A host reaches it over a plain 32-bit register bus with an address, a write enable, write data and combinational read data. Through one control word it drives two reset styles for every channel. The first is a one-clock pulse that restarts the channel's receive clock recovery and re-centres its jitter buffer pointers. The second is a level reset for the channel's logic and registers, which stays asserted until software clears it.

The block also gathers interrupt requests. Each channel's line interface, pattern tester and framer supply a request level, and a single packet engine supplies one more. These levels are presented in a read-only status word, and the block cannot clear them. Each one stays asserted until the source clears its own latched status. A read/write enable word with the same bit layout selects which requests reach a single registered interrupt output. A read-only word returns a device code and a revision, both fixed by parameters.

Top module: `chan_reset_irq_hub`

## Requirements
- R1: After reset, the control word and the enable word read 0, every reset output is 0, and the interrupt output is 0.
- R2: The control word at offset 0x08 reads back as last written. Bits [2N-1:N] are the receive resets and bits [N-1:0] are the software resets, with channel 1 at the lowest bit of each field. All higher bits read 0.
- R3: When a write to 0x08 changes receive bit N+i from 0 to 1, rxRstPulse[i] is high for exactly one clock, in the cycle right after the write edge.
- R4: Writing 1 to a receive bit that already holds 1 gives no pulse. Writing 0 gives no pulse. A later 0-to-1 change gives a pulse again.
- R5: swRst[i] equals software bit i of the control word. It changes in the cycle after the write and holds between writes.
- R6: Offset 0x0C reads {16'h0, DEV_CODE[11:0], DEV_REV[3:0]}. Writes to it have no effect.
- R7: Offset 0x10 reads the live request levels: bit 3N is the packet engine, [3N-1:2N] the line interfaces, [2N-1:N] the pattern testers and [N-1:0] the framers, with channel 1 at the low bit of each field. Higher bits read 0.
- R8: A write to 0x10 changes no status bit, no enable bit and no reset output.
- R9: The enable word at 0x14 is read/write with the status layout. Bits above 3N read 0. A 1 lets the matching request through.
- R10: irqOut is the OR of all status bits ANDed with their enable bits, registered, so it follows a change of a request or of the enable word one clock later.
- R11: Other offsets read 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | ADDR_W | Register byte offset |
| regWe | input | 1 | Write enable, one write per clock |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for regAddr, combinational |
| lineIrq | input | NUM_CHAN | Line-interface request levels |
| testIrq | input | NUM_CHAN | Pattern-tester request levels |
| framerIrq | input | NUM_CHAN | Framer request levels |
| pktIrq | input | 1 | Packet-engine request level |
| rxRstPulse | output | NUM_CHAN | One-clock receive restart pulse per channel |
| swRst | output | NUM_CHAN | Held software reset per channel |
| irqOut | output | 1 | Registered combined interrupt |

## Verification
The bench builds the block with eight channels, which fills every field up to bit 24. The tests therefore reach both ends of each field, channel 1 and channel 8, and the unused bits above the packet-engine bit. The device code and revision are overridden with values other than the defaults, so the identification check follows the parameters rather than a constant. With eight channels, a single write can start a pulse on one channel while another channel's bit stays at 1. This is how retriggering is checked one channel at a time.

// File: rtl/hub_pkg.sv
package hub_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned OFS_CTRL = 'h08;
  localparam int unsigned OFS_ID   = 'h0C;
  localparam int unsigned OFS_STAT = 'h10;
  localparam int unsigned OFS_MASK = 'h14;

  // Strobes from address decode into the datapath.
  typedef struct packed {
    logic wrCtrl;
    logic wrMask;
    logic rdCtrl;
    logic rdId;
    logic rdStat;
    logic rdMask;
  } hubStrobe_t;
endpackage

// File: rtl/hub_ctrl.sv
module hub_ctrl
  import hub_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  output hubStrobe_t        strobe
);
  localparam logic [ADDR_W-1:0] ofsCtrl = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] ofsId   = ADDR_W'(OFS_ID);
  localparam logic [ADDR_W-1:0] ofsStat = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] ofsMask = ADDR_W'(OFS_MASK);

  logic hitCtrl, hitId, hitStat, hitMask;

  always_comb begin
    hitCtrl = (regAddr == ofsCtrl);
    hitId   = (regAddr == ofsId);
    hitStat = (regAddr == ofsStat);
    hitMask = (regAddr == ofsMask);

    strobe        = '0;
    // Status and identification words ignore writes, so they get no write strobe.
    strobe.wrCtrl = regWe & hitCtrl;
    strobe.wrMask = regWe & hitMask;
    strobe.rdCtrl = hitCtrl;
    strobe.rdId   = hitId;
    strobe.rdStat = hitStat;
    strobe.rdMask = hitMask;
  end
endmodule

// File: rtl/hub_chan_rst.sv
// One channel's pair of reset controls: a pulse on a rising receive bit,
// and a level that follows the software bit.
module hub_chan_rst (
  input  logic clk,
  input  logic rstN,
  input  logic wrEn,
  input  logic rxNew,
  input  logic swNew,
  output logic rxBit,
  output logic swBit,
  output logic rxPulse
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxBit   <= 1'b0;
      swBit   <= 1'b0;
      rxPulse <= 1'b0;
    end else begin
      // Edge found by comparing the new value with the stored one.
      rxPulse <= wrEn & rxNew & ~rxBit;
      if (wrEn) begin
        rxBit <= rxNew;
        swBit <= swNew;
      end
    end
  end
endmodule

// File: rtl/hub_datapath.sv
module hub_datapath
  import hub_pkg::*;
#(
  parameter int unsigned NUM_CHAN = 8,
  parameter logic [11:0] DEV_CODE = 12'h3A1,
  parameter logic [3:0]  DEV_REV  = 4'h1
) (
  input  logic                clk,
  input  logic                rstN,
  input  hubStrobe_t          strobe,
  input  logic [DATA_W-1:0]   regWdata,
  input  logic [NUM_CHAN-1:0] lineIrq,
  input  logic [NUM_CHAN-1:0] testIrq,
  input  logic [NUM_CHAN-1:0] framerIrq,
  input  logic                pktIrq,
  output logic [DATA_W-1:0]   regRdata,
  output logic [NUM_CHAN-1:0] rxRstPulse,
  output logic [NUM_CHAN-1:0] swRst,
  output logic                irqOut,
  output logic [3*NUM_CHAN:0] maskQ
);
  localparam int unsigned CTRL_W = 2 * NUM_CHAN;
  localparam int unsigned STAT_W = 3 * NUM_CHAN + 1;

  logic [NUM_CHAN-1:0] rxCtlQ;
  logic [STAT_W-1:0]   statVec;
  logic                unusedWdata;

  assign unusedWdata = ^regWdata[DATA_W-1:STAT_W];
  assign statVec     = {pktIrq, lineIrq, testIrq, framerIrq};

  for (genvar ch = 0; ch < NUM_CHAN; ch++) begin : g_chan
    hub_chan_rst u_rst (
      .clk    (clk),
      .rstN   (rstN),
      .wrEn   (strobe.wrCtrl),
      .rxNew  (regWdata[NUM_CHAN + ch]),
      .swNew  (regWdata[ch]),
      .rxBit  (rxCtlQ[ch]),
      .swBit  (swRst[ch]),
      .rxPulse(rxRstPulse[ch])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ  <= '0;
      irqOut <= 1'b0;
    end else begin
      if (strobe.wrMask) maskQ <= regWdata[STAT_W-1:0];
      irqOut <= |(statVec & maskQ);
    end
  end

  always_comb begin
    regRdata = '0;
    if (strobe.rdCtrl) regRdata = DATA_W'({rxCtlQ, swRst});
    if (strobe.rdId)   regRdata = {16'h0000, DEV_CODE, DEV_REV};
    if (strobe.rdStat) regRdata = DATA_W'(statVec);
    if (strobe.rdMask) regRdata = DATA_W'(maskQ);
  end

  logic [CTRL_W-1:0] unusedCtrlView;
  assign unusedCtrlView = {rxCtlQ, swRst};
endmodule

// File: rtl/chan_reset_irq_hub.sv
module chan_reset_irq_hub
  import hub_pkg::*;
#(
  parameter int unsigned NUM_CHAN = 8,   // 3*NUM_CHAN+1 must fit in 32 bits
  parameter int unsigned ADDR_W   = 8,
  parameter logic [11:0] DEV_CODE = 12'h3A1,
  parameter logic [3:0]  DEV_REV  = 4'h1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic                regWe,
  input  logic [31:0]         regWdata,
  output logic [31:0]         regRdata,
  input  logic [NUM_CHAN-1:0] lineIrq,
  input  logic [NUM_CHAN-1:0] testIrq,
  input  logic [NUM_CHAN-1:0] framerIrq,
  input  logic                pktIrq,
  output logic [NUM_CHAN-1:0] rxRstPulse,
  output logic [NUM_CHAN-1:0] swRst,
  output logic                irqOut
);
  hubStrobe_t          strobe;
  logic [3*NUM_CHAN:0] maskQ;

  hub_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .regAddr(regAddr),
    .regWe  (regWe),
    .strobe (strobe)
  );

  hub_datapath #(
    .NUM_CHAN(NUM_CHAN),
    .DEV_CODE(DEV_CODE),
    .DEV_REV (DEV_REV)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .regWdata  (regWdata),
    .lineIrq   (lineIrq),
    .testIrq   (testIrq),
    .framerIrq (framerIrq),
    .pktIrq    (pktIrq),
    .regRdata  (regRdata),
    .rxRstPulse(rxRstPulse),
    .swRst     (swRst),
    .irqOut    (irqOut),
    .maskQ     (maskQ)
  );
endmodule

// File: rtl/hub_checker.sv
module hub_checker
  import hub_pkg::*;
#(
  parameter int unsigned NUM_CHAN = 8,
  parameter int unsigned ADDR_W   = 8,
  parameter logic [11:0] DEV_CODE = 12'h3A1,
  parameter logic [3:0]  DEV_REV  = 4'h1
) (
  input logic                clk,
  input logic                rstN,
  input logic [ADDR_W-1:0]   regAddr,
  input logic                regWe,
  input logic [31:0]         regRdata,
  input logic [NUM_CHAN-1:0] lineIrq,
  input logic [NUM_CHAN-1:0] testIrq,
  input logic [NUM_CHAN-1:0] framerIrq,
  input logic                pktIrq,
  input logic [NUM_CHAN-1:0] rxRstPulse,
  input logic [NUM_CHAN-1:0] swRst,
  input logic                irqOut,
  input logic [3*NUM_CHAN:0] maskQ
);
  localparam int unsigned STAT_W = 3 * NUM_CHAN + 1;
  localparam logic [ADDR_W-1:0] aCtrl = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] aId   = ADDR_W'(OFS_ID);
  localparam logic [ADDR_W-1:0] aStat = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] aMask = ADDR_W'(OFS_MASK);

  logic [STAT_W-1:0] reqVec;
  assign reqVec = {pktIrq, lineIrq, testIrq, framerIrq};

  assert_pulse_one_wide_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rxRstPulse & $past(rxRstPulse)) == '0);

  assert_pulse_after_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    (|rxRstPulse) |-> $past(regWe && regAddr == aCtrl));

  assert_sw_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(regWe && regAddr == aCtrl) |=> $stable(swRst));

  assert_id_word_R6: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == aId) |-> regRdata == {16'h0000, DEV_CODE, DEV_REV});

  assert_stat_word_R7: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == aStat) |-> regRdata == 32'(reqVec));

  assert_mask_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(regWe && regAddr == aMask) |=> $stable(maskQ));

  assert_irq_follow_R10: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> irqOut == |($past(reqVec & maskQ)));
endmodule

bind chan_reset_irq_hub hub_checker #(
  .NUM_CHAN(NUM_CHAN),
  .ADDR_W  (ADDR_W),
  .DEV_CODE(DEV_CODE),
  .DEV_REV (DEV_REV)
) u_hub_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regAddr   (regAddr),
  .regWe     (regWe),
  .regRdata  (regRdata),
  .lineIrq   (lineIrq),
  .testIrq   (testIrq),
  .framerIrq (framerIrq),
  .pktIrq    (pktIrq),
  .rxRstPulse(rxRstPulse),
  .swRst     (swRst),
  .irqOut    (irqOut),
  .maskQ     (maskQ)
);

// File: tb/test_chan_reset_irq_hub.sv
module test_chan_reset_irq_hub;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;
  localparam logic [11:0] CODE = 12'hC47;
  localparam logic [3:0]  REV  = 4'h9;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  regAddr = 8'hFC;
  logic        regWe = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [NCH-1:0] lineIrq = '0, testIrq = '0, framerIrq = '0;
  logic        pktIrq = 1'b0;
  logic [NCH-1:0] rxRstPulse, swRst;
  logic        irqOut;

  int nChk = 0;
  int nBad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chan_reset_irq_hub #(
    .NUM_CHAN(NCH), .ADDR_W(8), .DEV_CODE(CODE), .DEV_REV(REV)
  ) i_chan_reset_irq_hub (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .lineIrq(lineIrq),
    .testIrq(testIrq), .framerIrq(framerIrq), .pktIrq(pktIrq),
    .rxRstPulse(rxRstPulse), .swRst(swRst), .irqOut(irqOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Returns at the falling edge that follows the write edge.
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWe = 1'b1; regWdata = d;
    @(negedge clk);
    regWe = 1'b0; regAddr = 8'hFC; regWdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = regRdata;
    regAddr = 8'hFC;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 swRst", 32'(swRst), 0);
    chk("R1 rxRstPulse", 32'(rxRstPulse), 0);
    chk("R1 irqOut", 32'(irqOut), 0);
    rd(8'h08, d); chk("R1 ctrl word", d, 0);
    rd(8'h14, d); chk("R1 mask word", d, 0);
  endtask

  task automatic t_ctrl_readback;
    logic [31:0] d;
    wr(8'h08, 32'hFFFF_A5C3);
    chk("R3 pulses on first set", 32'(rxRstPulse), 32'h0000_00A5);
    rd(8'h08, d); chk("R2 readback", d, 32'h0000_A5C3);
    wr(8'h08, 32'h0);
    rd(8'h08, d); chk("R2 cleared", d, 0);
  endtask

  task automatic t_rx_pulse;
    wr(8'h08, 32'h0000_0100);
    chk("R3 ch1 pulse", 32'(rxRstPulse), 32'h01);
    @(negedge clk);
    chk("R3 ch1 pulse ends", 32'(rxRstPulse), 0);
    wr(8'h08, 32'h0000_8100);
    chk("R3 ch8 pulse only", 32'(rxRstPulse), 32'h80);
    @(negedge clk);
    chk("R3 ch8 pulse ends", 32'(rxRstPulse), 0);
  endtask

  task automatic t_rx_retrigger;
    wr(8'h08, 32'h0000_8100);
    chk("R4 rewrite one", 32'(rxRstPulse), 0);
    wr(8'h08, 32'h0);
    chk("R4 write zero", 32'(rxRstPulse), 0);
    chk("R4 sw untouched", 32'(swRst), 0);
    wr(8'h08, 32'h0000_0100);
    chk("R4 retrigger", 32'(rxRstPulse), 32'h01);
    wr(8'h08, 32'h0);
  endtask

  task automatic t_sw_level;
    wr(8'h08, 32'h0000_0081);
    chk("R5 sw set", 32'(swRst), 32'h81);
    chk("R5 no rx pulse", 32'(rxRstPulse), 0);
    repeat (5) @(negedge clk);
    chk("R5 sw held", 32'(swRst), 32'h81);
    wr(8'h08, 32'h0000_0001);
    chk("R5 ch8 released", 32'(swRst), 32'h01);
    wr(8'h08, 32'h0);
    chk("R5 all released", 32'(swRst), 0);
  endtask

  task automatic t_id;
    logic [31:0] d;
    rd(8'h0C, d); chk("R6 id", d, 32'h0000_C479);
    wr(8'h08, 32'h0000_0002);
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h0C, d); chk("R6 id after write", d, 32'h0000_C479);
    rd(8'h08, d); chk("R6 ctrl untouched", d, 32'h0000_0002);
    wr(8'h08, 32'h0);
  endtask

  task automatic t_status;
    logic [31:0] d;
    pktIrq = 1'b1; lineIrq = 8'h80; testIrq = 8'h01; framerIrq = 8'h5A;
    rd(8'h10, d); chk("R7 mixed", d, 32'h0180_015A);
    pktIrq = 1'b1; lineIrq = 8'hFF; testIrq = 8'hFF; framerIrq = 8'hFF;
    rd(8'h10, d); chk("R7 all set", d, 32'h01FF_FFFF);
    pktIrq = 1'b0; lineIrq = 8'h01; testIrq = 8'h00; framerIrq = 8'h80;
    rd(8'h10, d); chk("R7 edges", d, 32'h0001_0080);
  endtask

  task automatic t_stat_write;
    logic [31:0] d;
    wr(8'h10, 32'h0);
    rd(8'h10, d); chk("R8 status kept", d, 32'h0001_0080);
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h14, d); chk("R8 mask untouched", d, 0);
    chk("R8 sw untouched", 32'(swRst), 0);
    chk("R8 no pulse", 32'(rxRstPulse), 0);
    lineIrq = '0; framerIrq = '0;
  endtask

  task automatic t_mask;
    logic [31:0] d;
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h14, d); chk("R9 mask all", d, 32'h01FF_FFFF);
    wr(8'h14, 32'h0042_1800);
    rd(8'h14, d); chk("R9 mask pattern", d, 32'h0042_1800);
    wr(8'h14, 32'h0);
  endtask

  task automatic t_irq;
    wr(8'h14, 32'h0001_0000);
    chk("R10 idle", 32'(irqOut), 0);
    lineIrq = 8'h01;
    #1 chk("R10 not yet", 32'(irqOut), 0);
    @(negedge clk);
    chk("R10 line ch1", 32'(irqOut), 1);
    lineIrq = 8'h00; framerIrq = 8'hFF;
    @(negedge clk);
    chk("R10 masked framer", 32'(irqOut), 0);
    pktIrq = 1'b1;
    wr(8'h14, 32'h0100_0000);
    chk("R10 mask lag", 32'(irqOut), 0);
    @(negedge clk);
    chk("R10 packet", 32'(irqOut), 1);
    wr(8'h14, 32'h0);
    chk("R10 unmask lag", 32'(irqOut), 1);
    @(negedge clk);
    chk("R10 all masked", 32'(irqOut), 0);
    pktIrq = 1'b0; framerIrq = 8'h00;
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    rd(8'h04, d); chk("R11 read 0x04", d, 0);
    rd(8'h18, d); chk("R11 read 0x18", d, 0);
    wr(8'h00, 32'hFFFF_FFFF);
    chk("R11 no pulse", 32'(rxRstPulse), 0);
    wr(8'h18, 32'hFFFF_FFFF);
    rd(8'h08, d); chk("R11 ctrl kept", d, 0);
    rd(8'h14, d); chk("R11 mask kept", d, 0);
    chk("R11 sw kept", 32'(swRst), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl_readback();
    t_rx_pulse();
    t_rx_retrigger();
    t_sw_level();
    t_id();
    t_status();
    t_stat_write();
    t_mask();
    t_irq();
    t_unmapped();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChk++;
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end
endmodule